// File: doc/BRIEF.md
# Half-Bridge Dead-Time and Shoot-Through Guard

This block sits between the PWM request inputs of one half-bridge and the enables of its high-side and low-side gate drivers. It passes each request to its own output, but it never lets both outputs be high together. When both requests are high at once, the block turns both outputs off and raises a sticky cross-conduction fault.

Each turn-on is also held back until the opposite switch has been off long enough. The minimum off interval is a count of clock cycles taken from a static input. In independent-input mode with adaptive dead time selected, the block measures the interval in which both outputs are off. If the controller already left a gap of at least the programmed length, a request passes straight through; if the gap was shorter, only the missing part is added. In every other configuration, each turn-on request waits the full programmed count.

All configuration inputs are static, and they are changed only while both inputs are low. Every output is registered, so a request that is allowed at once shows up one clock after it is sampled.

Top module: `hb_deadband_guard`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both outputs and `xc_fault` are low after that edge. The dead-time counter also restarts from zero.
- R2: If `in_hi` and `in_lo` are both high at a clock edge, both outputs are low after that edge, whatever the configuration.
- R3: If `in_hi` and `in_lo` are both high at an edge while `st_flag_mask` is 0, `xc_fault` is 1 after that edge. It stays 1 until an edge at which `fault_clr` is 1 and no new setting condition is present. If setting and clearing happen at the same edge, setting wins.
- R4: While `st_flag_mask` is 1, simultaneous high inputs never set `xc_fault`, but the outputs are still forced low. The mask is meant to be 1 in every PWM mode other than 000.
- R5: `out_hi` and `out_lo` are never both high. An output is high after an edge only if, at that edge, its own input was high and the opposite input was low.
- R6: Adaptive dead time is in force only when `pwm_mode` is 3'b000, `dt_force` is 0 and `dt_indep_sel` is 2'b00. In that case, a request sampled after both outputs have been low for at least `dead_cycles` clock cycles turns its output on at that same edge.
- R7: In adaptive mode, when the controller's gap is shorter than D = `dead_cycles`, the output rises at the edge D cycles after the opposite output fell. An interval in which both inputs were high counts as part of the gap.
- R8: In all other configurations (any `pwm_mode` other than 000, or `dt_force` = 1, or `dt_indep_sel` not 00), take the first edge at which a request is sampled while both outputs are already low. The output rises D edges after that edge. On a direct crossover, the first such edge is the one after the opposite output falls, so the rise comes D+1 edges after the crossover edge.
- R9: If a request drops while its turn-on is still being held back, no pulse appears. In the always-insert configuration, a later request waits the full D again.
- R10: With `dead_cycles` = 0 no delay is added. A direct crossover switches one output off and the other on at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_mode | input | 3 | PWM mode select; 000 means independent inputs |
| dt_force | input | 1 | 1 forces dead time on every turn-on |
| dt_indep_sel | input | 2 | Dead-time option for independent mode; 00 selects adaptive |
| st_flag_mask | input | 1 | 1 suppresses the cross-conduction fault flag |
| dead_cycles | input | DT_W | Dead time in clock cycles |
| fault_clr | input | 1 | Clears the sticky fault |
| in_hi | input | 1 | High-side PWM request |
| in_lo | input | 1 | Low-side PWM request |
| out_hi | output | 1 | High-side gate enable |
| out_lo | output | 1 | Low-side gate enable |
| xc_fault | output | 1 | Sticky cross-conduction fault |

## Verification
The bench targets several corner cases, each of which exposes a specific design error:
- A controller gap exactly equal to D, which must pass through with no delay. A comparison that is off by one would delay that edge.
- A gap that is too short, which must be padded only up to D. A design that always pads would add the full D, and one that never pads would skip the padding.
- A both-high burst counted as part of the gap, and a clear pulse that arrives together with a new both-high sample. A design with clear priority would drop the fault.
- A request withdrawn during the wait in always-insert mode. Without a counter restart, the next request would fire early.
- The D+1 crossover latency and the zero dead time case.

// File: rtl/hb_deadband_guard.sv
module hb_deadband_guard #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      pwm_mode,
  input  logic            dt_force,
  input  logic [1:0]      dt_indep_sel,
  input  logic            st_flag_mask,
  input  logic [DT_W-1:0] dead_cycles,
  input  logic            fault_clr,
  input  logic            in_hi,
  input  logic            in_lo,
  output logic            out_hi,
  output logic            out_lo,
  output logic            xc_fault
);
  localparam logic [DT_W-1:0] CNT_MAX = '1;
  localparam logic [DT_W:0]   ONE_W   = (DT_W+1)'(1);

  logic [DT_W-1:0] gap_cnt;
  logic [DT_W:0]   gap_cmp;
  logic            adaptive, both_on, req_hi, req_lo, outs_off, allow;

  assign adaptive = (pwm_mode == 3'b000) && !dt_force && (dt_indep_sel == 2'b00);
  assign both_on  = in_hi & in_lo;
  assign req_hi   = in_hi & ~in_lo;
  assign req_lo   = in_lo & ~in_hi;
  assign outs_off = ~out_hi & ~out_lo;
  assign gap_cmp  = adaptive ? ({1'b0, gap_cnt} + ONE_W) : {1'b0, gap_cnt};
  assign allow    = (dead_cycles == '0) || (outs_off && (gap_cmp >= {1'b0, dead_cycles}));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_hi   <= 1'b0;
      out_lo   <= 1'b0;
      gap_cnt  <= '0;
      xc_fault <= 1'b0;
    end else begin
      out_hi <= req_hi & (out_hi | allow);
      out_lo <= req_lo & (out_lo | allow);

      if (!outs_off)
        gap_cnt <= '0;
      else if (!adaptive && !(req_hi | req_lo))
        gap_cnt <= '0;
      else if (gap_cnt != CNT_MAX)
        gap_cnt <= gap_cnt + 1'b1;

      if (both_on && !st_flag_mask)
        xc_fault <= 1'b1;
      else if (fault_clr)
        xc_fault <= 1'b0;
    end
  end
endmodule

// File: rtl/hb_deadband_guard_chk.sv
module hb_deadband_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic st_flag_mask,
  input logic fault_clr,
  input logic in_hi,
  input logic in_lo,
  input logic out_hi,
  input logic out_lo,
  input logic xc_fault
);
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_hi && out_lo)); // R5

  AST_BOTH_HIGH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hi && in_lo) |=> (!out_hi && !out_lo)); // R2

  AST_HI_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_hi && !in_lo) |=> !out_hi); // R5

  AST_LO_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_lo && !in_hi) |=> !out_lo); // R5

  AST_FAULT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hi && in_lo && !st_flag_mask) |=> xc_fault); // R3

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (xc_fault && !fault_clr) |=> xc_fault); // R3

  AST_FAULT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!xc_fault && st_flag_mask) |=> !xc_fault); // R4
endmodule

bind hb_deadband_guard hb_deadband_guard_chk u_chk (.*);

// File: tb/sim_hb_deadband_guard.sv
module sim_hb_deadband_guard;
  localparam int DT_W = 8;
  localparam int NV   = 29;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [2:0]      pwm_mode = 3'b000;
  logic            dt_force = 1'b0;
  logic [1:0]      dt_indep_sel = 2'b00;
  logic            st_flag_mask = 1'b0;
  logic [DT_W-1:0] dead_cycles = 8'd3;
  logic            fault_clr = 1'b0;
  logic            in_hi = 1'b0;
  logic            in_lo = 1'b0;
  logic            out_hi, out_lo, xc_fault;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hb_deadband_guard #(.DT_W(DT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .pwm_mode(pwm_mode), .dt_force(dt_force),
    .dt_indep_sel(dt_indep_sel), .st_flag_mask(st_flag_mask),
    .dead_cycles(dead_cycles), .fault_clr(fault_clr),
    .in_hi(in_hi), .in_lo(in_lo), .out_hi(out_hi), .out_lo(out_lo),
    .xc_fault(xc_fault)
  );

  // {in_hi, in_lo, exp_hi, exp_lo, exp_fault}: adaptive mode, D = 3, flag unmasked
  localparam logic [4:0] VEC [NV] = '{
    5'b00_000, 5'b00_000, 5'b00_000,   // idle gap builds up
    5'b10_100, 5'b10_100,              // R6 long gap passes at once
    5'b01_000, 5'b01_000, 5'b01_000,   // R7 zero gap crossover padded
    5'b01_010, 5'b01_010,
    5'b00_000, 5'b00_000,
    5'b10_000, 5'b10_100, 5'b10_100,   // R7 two-cycle gap padded by one
    5'b00_000, 5'b00_000, 5'b00_000,
    5'b01_010,                         // R6 gap exactly D passes
    5'b11_001, 5'b11_001,              // R2 R3 both high
    5'b00_001, 5'b10_101,              // R7 both-high time counts as gap
    5'b11_001, 5'b00_001,
    5'b01_001, 5'b00_001,              // R9 withdrawn request, no pulse
    5'b00_001, 5'b01_011
  };

  task automatic check(input string tag, input logic [2:0] exp);
    logic [2:0] act;
    act = {out_hi, out_lo, xc_fault};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {hi,lo,flt} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input logic h, input logic l, input logic [2:0] exp, input string tag);
    in_hi = h;
    in_lo = l;
    @(negedge clk);
    check(tag, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", 3'b000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][4], VEC[i][3], VEC[i][2:0], $sformatf("R5/R6/R7 vector %0d", i));
    end

    // R3 clear, then set wins over clear
    fault_clr = 1'b1;
    step(0, 0, 3'b000, "R3 clear");
    step(1, 1, 3'b001, "R3 set beats clear");
    fault_clr = 1'b0;
    step(0, 0, 3'b001, "R3 sticky");
    fault_clr = 1'b1;
    step(0, 0, 3'b000, "R3 clear again");
    fault_clr = 1'b0;

    // R4 masked flag
    st_flag_mask = 1'b1;
    step(1, 1, 3'b000, "R4 masked both high");
    step(1, 1, 3'b000, "R4 masked both high");
    step(0, 0, 3'b000, "R4 idle");

    // R10 zero dead time
    dead_cycles = '0;
    step(1, 0, 3'b100, "R10 hi on");
    step(0, 1, 3'b010, "R10 crossover");
    step(1, 0, 3'b100, "R10 crossover back");
    step(0, 0, 3'b000, "R10 idle");

    // R8 always-insert via non-independent PWM mode
    pwm_mode = 3'b001;
    dead_cycles = 8'd3;
    step(0, 0, 3'b000, "R8 idle");
    step(1, 0, 3'b000, "R8 wait 1");
    step(1, 0, 3'b000, "R8 wait 2");
    step(1, 0, 3'b000, "R8 wait 3");
    step(1, 0, 3'b100, "R8 rise after D");
    step(1, 0, 3'b100, "R8 hold");
    step(0, 1, 3'b000, "R8 crossover edge");
    step(0, 1, 3'b000, "R8 cross wait 1");
    step(0, 1, 3'b000, "R8 cross wait 2");
    step(0, 1, 3'b000, "R8 cross wait 3");
    step(0, 1, 3'b010, "R8 rise after D+1");

    // R9 cancel in always-insert mode
    step(0, 0, 3'b000, "R9 idle");
    step(1, 0, 3'b000, "R9 wait 1");
    step(1, 0, 3'b000, "R9 wait 2");
    step(0, 0, 3'b000, "R9 withdrawn");
    step(1, 0, 3'b000, "R9 restart 1");
    step(1, 0, 3'b000, "R9 restart 2");
    step(1, 0, 3'b000, "R9 restart 3");
    step(1, 0, 3'b100, "R9 full D after restart");

    // R8 always-insert via independent mode option 01
    pwm_mode = 3'b000;
    dt_indep_sel = 2'b01;
    step(0, 0, 3'b000, "R8 sel01 idle");
    step(0, 0, 3'b000, "R8 sel01 idle");
    step(0, 1, 3'b000, "R8 sel01 wait 1");
    step(0, 1, 3'b000, "R8 sel01 wait 2");
    step(0, 1, 3'b000, "R8 sel01 wait 3");
    step(0, 1, 3'b010, "R8 sel01 rise");

    // R1 reset clears outputs and fault mid-run
    dt_indep_sel = 2'b00;
    st_flag_mask = 1'b0;
    step(1, 1, 3'b001, "R3 set before reset");
    rst_n = 1'b0;
    step(0, 1, 3'b000, "R1 reset mid-run");
    rst_n = 1'b1;
    step(1, 0, 3'b000, "R1 counter restarted");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule